// File: doc/BRIEF.md
# Programmable Interval Timer Channel

The block is a single timer channel behind a small 32-bit register bus made of a write strobe, a read strobe, a two-bit word index and the two data buses. Software programs a period (the limit), a clock divisor and a mode, then sets the run bit. A prescaler divides the input clock by the divisor. On each prescaler tick a 28-bit counter steps up by one. When the counter steps onto the limit, the block sets a pending flag. The level-sensitive interrupt output is that flag gated by an interrupt-enable bit.

There are two modes. In one-shot mode the channel clears its own run bit on the event and the counter holds at the limit. In repeat mode the counter goes back to zero and keeps running, so the events are spaced evenly. The pending flag stays set until software writes a one to it. Stopping the timer or masking the interrupt does not clear it.

Word index to byte offset: index 0 is byte 0x0, index 1 is 0x4, index 2 is 0x8 and index 3 is 0xC.

Top module: `prog_timer`

## Requirements
- R1: Word 0 (offset 0x0) holds the 28-bit limit in bits 27:0. Word 1 (0x4) holds the live count in bits 27:0. Word 2 (0x8) holds the run bit at 28, the mode bit at 24 (1 = repeat, 0 = one-shot) and the 16-bit divisor field in 15:0. Word 3 (0xC) holds the pending flag at bit 16 and the interrupt enable at bit 20. Every other bit reads as zero.
- R2: A synchronous active-high reset clears every register, so all four words read zero and irq is low.
- R3: The counter advances once every D input clocks, where D is the divisor field, and a field value of 0 or 1 counts as 2. Start with count 0 and limit L, then write the run bit. The pending flag is set on the L*D-th rising edge after the edge that performed the write.
- R4: In one-shot mode the event clears the run bit, and the count then holds at the limit.
- R5: In repeat mode the event returns the count to 0 and counting continues, so consecutive events are L*D clocks apart.
- R6: Writing 1 to bit 16 of word 3 clears the pending flag. Writing 0 to that bit leaves it unchanged. The flag stays set while the timer is stopped or masked.
- R7: irq is high exactly when both the pending flag and the interrupt enable bit 20 are set.
- R8: Writing word 2 with the run bit at 0 stops the timer, and the count then stays frozen.
- R9: A write to word 1 loads bits 27:0 into the count and restarts the prescaler. From count C, the event comes (L-C)*D clocks later.
- R10: rdData is zero whenever rdEn is low. While rdEn is high, rdData shows the addressed word in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Write strobe, one cycle per write |
| rdEn | input | 1 | Read strobe, data returned in the same cycle |
| regWord | input | 2 | Word index (byte offset divided by 4) |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data |
| irq | output | 1 | Level interrupt request |

## Verification
The bench goes after the divisor floor. A design that took a divisor of 0 or 1 literally would fire its event early, or never. It measures the exact edge of each event; an off-by-one in the prescaler or the compare would move every period by D clocks or by one clock. It also checks one-shot hold against repeat wrap: a one-shot that kept running, or a repeat that stopped, shows up as a wrong count or a missing second event. Finally it checks that the pending flag survives masking and stopping, and that only a written one clears it. A write-zero clear, or a flag tied to the enable, would break those checks.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W   = 32;
  localparam int CNT_W    = 28;
  localparam int DIV_W    = 16;
  localparam int RUN_BIT  = 28;
  localparam int MODE_BIT = 24;
  localparam int PEND_BIT = 16;
  localparam int IE_BIT   = 20;
  localparam int MIN_DIV  = 2;

  typedef enum logic [1:0] {
    SEL_LIMIT = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_INT   = 2'd3
  } regSel_e;

  // strobes and settings from the register/control side to the datapath
  typedef struct packed {
    logic             loadLimit;
    logic             loadCount;
    logic             restartPre;
    logic             runEn;
    logic             repeatMode;
    logic [DIV_W-1:0] divisor;
    logic [CNT_W-1:0] wrValue;
  } tmrCmd_t;
endpackage

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  tmrCmd_t          cmd,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] limit,
  output logic             hitPulse
);
  logic [DIV_W-1:0] preCnt;
  logic [DIV_W-1:0] effDiv;
  logic [CNT_W-1:0] countInc;
  logic             tick;

  always_comb begin
    effDiv   = (cmd.divisor < DIV_W'(MIN_DIV)) ? DIV_W'(MIN_DIV) : cmd.divisor;
    tick     = cmd.runEn && !cmd.restartPre && (preCnt == effDiv - 1'b1);
    countInc = count + 1'b1;
    hitPulse = tick && !cmd.loadCount && (countInc == limit);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      preCnt <= '0;
      count  <= '0;
      limit  <= '0;
    end else begin
      if (cmd.loadLimit) limit <= cmd.wrValue;

      if (cmd.restartPre || !cmd.runEn || tick) preCnt <= '0;
      else                                      preCnt <= preCnt + 1'b1;

      if (cmd.loadCount)  count <= cmd.wrValue;
      else if (hitPulse)  count <= cmd.repeatMode ? '0 : countInc;
      else if (tick)      count <= countInc;
    end
  end

  // R3
  pre_range_chk: assert property (@(posedge clk) disable iff (rst)
    preCnt < effDiv);

  // R8
  count_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (!cmd.runEn && !cmd.loadCount) |=> $stable(count));

  // R5
  repeat_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (hitPulse && cmd.repeatMode) |=> (count == '0));

  // R4
  oneshot_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (hitPulse && !cmd.repeatMode) |=> (count == $past(limit)));
endmodule

// File: rtl/tmr_regs_ctrl.sv
module tmr_regs_ctrl
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [1:0]        regWord,
  input  logic [DATA_W-1:0] wrData,
  input  logic [CNT_W-1:0]  count,
  input  logic [CNT_W-1:0]  limit,
  input  logic              hitPulse,
  output tmrCmd_t           cmd,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  regSel_e          sel;
  logic             ctrlWr;
  logic             intWr;
  logic             runEn;
  logic             repeatMode;
  logic [DIV_W-1:0] divisor;
  logic             pending;
  logic             intEn;

  always_comb begin
    sel            = regSel_e'(regWord);
    ctrlWr         = wrEn && (sel == SEL_CTRL);
    intWr          = wrEn && (sel == SEL_INT);
    cmd.loadLimit  = wrEn && (sel == SEL_LIMIT);
    cmd.loadCount  = wrEn && (sel == SEL_COUNT);
    cmd.restartPre = ctrlWr || cmd.loadCount;
    cmd.runEn      = runEn;
    cmd.repeatMode = repeatMode;
    cmd.divisor    = divisor;
    cmd.wrValue    = wrData[CNT_W-1:0];
    irq            = pending && intEn;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      runEn      <= 1'b0;
      repeatMode <= 1'b0;
      divisor    <= '0;
      pending    <= 1'b0;
      intEn      <= 1'b0;
    end else begin
      if (ctrlWr) begin
        runEn      <= wrData[RUN_BIT];
        repeatMode <= wrData[MODE_BIT];
        divisor    <= wrData[DIV_W-1:0];
      end else if (hitPulse && !repeatMode) begin
        runEn <= 1'b0;
      end

      if (hitPulse)                        pending <= 1'b1;
      else if (intWr && wrData[PEND_BIT])  pending <= 1'b0;

      if (intWr) intEn <= wrData[IE_BIT];
    end
  end

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      unique case (sel)
        SEL_LIMIT: rdData[CNT_W-1:0] = limit;
        SEL_COUNT: rdData[CNT_W-1:0] = count;
        SEL_CTRL: begin
          rdData[RUN_BIT]   = runEn;
          rdData[MODE_BIT]  = repeatMode;
          rdData[DIV_W-1:0] = divisor;
        end
        SEL_INT: begin
          rdData[PEND_BIT] = pending;
          rdData[IE_BIT]   = intEn;
        end
        default: rdData = '0;
      endcase
    end
  end

  // R6
  pend_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pending) |-> $past(hitPulse));

  // R6
  pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pending && !(intWr && wrData[PEND_BIT])) |=> pending);

  // R4
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (hitPulse && !repeatMode && !ctrlWr) |=> !runEn);
endmodule

// File: rtl/prog_timer.sv
module prog_timer
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [1:0]        regWord,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  tmrCmd_t          cmd;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] limit;
  logic             hitPulse;

  tmr_regs_ctrl regs_i (
    .clk      (clk),
    .rst      (rst),
    .wrEn     (wrEn),
    .rdEn     (rdEn),
    .regWord  (regWord),
    .wrData   (wrData),
    .count    (count),
    .limit    (limit),
    .hitPulse (hitPulse),
    .cmd      (cmd),
    .rdData   (rdData),
    .irq      (irq)
  );

  tmr_datapath dp_i (
    .clk      (clk),
    .rst      (rst),
    .cmd      (cmd),
    .count    (count),
    .limit    (limit),
    .hitPulse (hitPulse)
  );
endmodule

// File: tb/prog_timer_tb_top.sv
`timescale 1ns/1ps
module prog_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [1:0]  regWord = 2'd0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irq;
  int          checks = 0;
  int          failures = 0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  prog_timer dut_i (
    .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn),
    .regWord(regWord), .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  function automatic int effDiv(int d);
    return (d < 2) ? 2 : d;
  endfunction

  function automatic logic [31:0] ctrlWord(bit run, bit rep, int d);
    return (32'(run) << 28) | (32'(rep) << 24) | 32'(d & 16'hFFFF);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [1:0] w, logic [31:0] d);
    regWord = w; wrData = d; wrEn = 1'b1;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic busRead(logic [1:0] w, output logic [31:0] d);
    regWord = w; rdEn = 1'b1;
    #0.1;
    d = rdData;
    rdEn = 1'b0;
  endtask

  task automatic waitIrq(int maxN, output int n);
    n = 0;
    while (irq !== 1'b1 && n < maxN) begin
      @(posedge clk); #1;
      n++;
    end
  endtask

  task automatic prep(int lim, bit ie);
    busWrite(2'd2, 32'h0);
    busWrite(2'd3, 32'h0001_0000 | (32'(ie) << 20));
    busWrite(2'd1, 32'h0);
    busWrite(2'd0, 32'(lim));
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, c1, c2;
    int n, n2;
    int unsigned seed;
    seed = $urandom(32'h5EED);

    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    check("R2 irq", 32'(irq), 0);
    for (int w = 0; w < 4; w++) begin
      busRead(2'(w), r);
      check("R2 reset word", r, 0);
    end

    // R1 field positions and unused bits
    busWrite(2'd0, 32'hFFFF_FFFF);
    busRead(2'd0, r); check("R1 limit width", r, 32'h0FFF_FFFF);
    busWrite(2'd2, 32'hFFFF_FFFF);
    busRead(2'd2, r); check("R1 ctrl fields", r, 32'h1100_FFFF);
    busWrite(2'd2, 32'h0);
    busWrite(2'd3, 32'hFFFF_FFFF);
    busRead(2'd3, r); check("R1 int fields", r, 32'h0010_0000);
    busWrite(2'd3, 32'h0);
    // R10 read gating
    regWord = 2'd0; #0.1;
    check("R10 idle read", rdData, 0);

    // one-shot, R3 R4 R7
    prep(5, 1);
    busWrite(2'd2, ctrlWord(1, 0, 3));
    waitIrq(1000, n);
    check("R3 oneshot period", 32'(n), 15);
    check("R7 irq high", 32'(irq), 1);
    busRead(2'd1, r); check("R4 count at limit", r, 5);
    busRead(2'd2, r); check("R4 run cleared", r, 32'h0000_0003);
    repeat (20) @(posedge clk); #1;
    busRead(2'd1, r); check("R4 count holds", r, 5);

    // R6 R7 pending survives masking, W1C
    busWrite(2'd3, 32'h0);
    check("R7 masked irq", 32'(irq), 0);
    busRead(2'd3, r); check("R6 pending kept", r, 32'h0001_0000);
    busWrite(2'd3, 32'h0001_0000);
    busRead(2'd3, r); check("R6 w1c clears", r, 0);

    // masked event with divisor 0 -> 2
    prep(3, 0);
    busWrite(2'd2, ctrlWord(1, 0, 0));
    repeat (10) @(posedge clk); #1;
    check("R7 masked event irq", 32'(irq), 0);
    busRead(2'd3, r); check("R6 masked pending", r, 32'h0001_0000);

    // divisor 1 -> 2
    prep(2, 1);
    busWrite(2'd2, ctrlWord(1, 0, 1));
    waitIrq(1000, n);
    check("R3 div1 floor", 32'(n), 4);

    // repeat R5
    prep(4, 1);
    busWrite(2'd2, ctrlWord(1, 1, 2));
    waitIrq(1000, n);
    check("R5 first period", 32'(n), 8);
    busRead(2'd1, r); check("R5 wrap to zero", r, 0);
    busWrite(2'd3, 32'h0011_0000);
    waitIrq(1000, n2);
    check("R5 second period", 32'(n2 + 1), 8);

    // stop R8
    busWrite(2'd2, 32'h0);
    busWrite(2'd3, 32'h0011_0000);
    repeat (3) @(posedge clk); #1;
    busRead(2'd1, c1);
    repeat (10) @(posedge clk); #1;
    busRead(2'd1, c2);
    check("R8 count frozen", c2, c1);
    check("R8 no event", 32'(irq), 0);

    // count load R9
    busWrite(2'd1, 32'hF000_0009);
    busRead(2'd1, r); check("R9 load width", r, 32'h0000_0009);
    prep(10, 1);
    busWrite(2'd1, 32'd7);
    busWrite(2'd2, ctrlWord(1, 0, 2));
    waitIrq(1000, n);
    check("R9 loaded start", 32'(n), 6);

    // constrained random runs
    for (int it = 0; it < 24; it++) begin
      int lim, d;
      bit rep;
      lim = 1 + int'($urandom % 30);
      d   = int'($urandom % 7);
      rep = 1'($urandom % 2);
      prep(lim, 1);
      busWrite(2'd2, ctrlWord(1, rep, d));
      waitIrq(5000, n);
      check("R3 random period", 32'(n), 32'(lim * effDiv(d)));
      busRead(2'd1, r);
      if (rep) check("R5 random wrap", r, 0);
      else begin
        check("R4 random hold", r, 32'(lim));
        busRead(2'd2, r);
        check("R4 random stop", r, ctrlWord(0, 0, d));
      end
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule